// File: doc/BRIEF.md
# Framed Configuration Byte Streamer

This block loads a programmable peripheral device over a byte-wide write port. On a start pulse it holds the active-low program line low for a fixed number of clocks and then releases it. It then waits, under a timeout, for the device's active-low ready line (`init_n`) to go high. Once the device is ready, it writes a fixed eight-byte header. The payload follows in 28-byte frames. Each frame carries 21 payload bytes between a preamble code and a check code, and ends with five padding bytes.

Payload arrives on a valid/ready byte stream, and `pl_last` marks its final byte. If the stream ends partway through a frame, the unused payload positions of that frame are filled with 0xFF. After the last frame the block writes four 0xFF startup bytes. It then samples the device's done line and reports either success or failure with an error code.

The block aborts at once if the device pulls `init_n` low, or raises done, while the header or frames are being written. Every write strobe is followed by at least `GAP` idle clocks, so a slow target port is never overrun.

Top module: `cfg_streamer`

## Requirements
- R1: After reset, `prog_n` is high, `wr_strobe`, `busy`, `ok`, `fail` and `pl_ready` are low, and `err_code` is 0.
- R2: A `start` pulse while idle drives `prog_n` low for exactly `PROG_LOW` clocks, after which it stays high until the next start.
- R3: If `init_n` is still low `INIT_WAIT` clocks after `prog_n` is released, the run ends with `fail` high, `err_code` = 1, and no byte is written.
- R4: Once `init_n` is high, the first eight bytes written are FF, FF, FF, 4F, 80, AF, 9B, 4B, in that order.
- R5: Each frame is 28 bytes, in this order: 4F, then 21 payload bytes in stream order, then 4B, FF, 4B, FF, FF, FF.
- R6: When `pl_last` is accepted before frame position 21, the remaining payload positions of that frame are written as FF and no further frame is started.
- R7: After the final frame, exactly four FF bytes are written. Once the gap after the last strobe has elapsed, `ok` goes high with `err_code` = 0 if `done_in` is high; otherwise `fail` goes high with `err_code` = 4.
- R8: If `init_n` is low during header or frame writing, no further byte is written and the run ends the next clock with `fail` high and `err_code` = 2.
- R9: If `done_in` is high (with `init_n` high) during header or frame writing, no further byte is written and the run ends the next clock with `fail` high and `err_code` = 3.
- R10: `wr_strobe` is one clock wide, and at least `GAP` clocks with `wr_strobe` low separate any two strobes (`GAP` >= 1).
- R11: `pl_ready` is high only at a payload position of a frame before `pl_last` has been accepted. Each accepted byte is written exactly once, and no byte is accepted without being written.
- R12: `ok` and `fail` are never high together. They hold their value while idle and clear on the clock that accepts the next `start`, when `busy` rises.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a load (sampled while idle) |
| prog_n | output | 1 | Active-low program/reset line to the target |
| init_n | input | 1 | Active-low not-ready line from the target |
| done_in | input | 1 | Target reports configuration complete |
| pl_data | input | 8 | Payload byte |
| pl_valid | input | 1 | Payload byte present |
| pl_last | input | 1 | Payload byte is the final one |
| pl_ready | output | 1 | Block takes the payload byte this clock |
| wr_strobe | output | 1 | One-clock write strobe to the target port |
| wr_data | output | 8 | Byte written with the strobe |
| busy | output | 1 | A load is in progress |
| ok | output | 1 | Last load succeeded |
| fail | output | 1 | Last load failed |
| err_code | output | 3 | 0 none, 1 ready timeout, 2 ready lost, 3 done early, 4 done missing |

## Verification
The hardest situations to reach are the aborts in the middle of a frame. They depend on the target model changing `init_n` or `done_in` exactly after a chosen byte count, not at a chosen time. The bench's target model counts the strobes it receives and flips those lines right after byte N. The expected byte count of an aborted run is therefore N exactly, with no byte written after the abort, and the number of payload bytes consumed is known exactly as well. Short payloads that end inside a frame, and payload that is valid only every other clock, cover the padding rule and the flow-control rule.

// File: rtl/cfg_stream_pkg.sv
package cfg_stream_pkg;

  localparam int POS_W     = 5;
  localparam int HDR_BYTES = 8;
  localparam int FRM_BYTES = 28;
  localparam int PAY_FIRST = 1;
  localparam int PAY_LAST  = 21;
  localparam int SUP_BYTES = 4;

  typedef enum logic [2:0] {
    ST_IDLE, ST_PROG, ST_WAIT, ST_HDR, ST_FRM, ST_SUP, ST_CHK
  } seq_state_e;

  typedef enum logic [2:0] {
    E_NONE       = 3'd0,
    E_TIMEOUT    = 3'd1,
    E_INIT_LOST  = 3'd2,
    E_DONE_EARLY = 3'd3,
    E_NOT_DONE   = 3'd4
  } cfg_err_e;

  // Header byte at position i
  function automatic logic [7:0] hdr_byte(input logic [POS_W-1:0] i);
    case (i)
      5'd3:    hdr_byte = 8'h4F;
      5'd4:    hdr_byte = 8'h80;
      5'd5:    hdr_byte = 8'hAF;
      5'd6:    hdr_byte = 8'h9B;
      5'd7:    hdr_byte = 8'h4B;
      default: hdr_byte = 8'hFF;
    endcase
  endfunction

  // Fixed (non-payload) byte at frame position p; payload slots read FF (pad value)
  function automatic logic [7:0] frm_fixed(input logic [POS_W-1:0] p);
    case (p)
      5'd0:        frm_fixed = 8'h4F;
      5'd22, 5'd24: frm_fixed = 8'h4B;
      default:     frm_fixed = 8'hFF;
    endcase
  endfunction

  function automatic logic is_pay(input logic [POS_W-1:0] p);
    is_pay = (p >= POS_W'(PAY_FIRST)) && (p <= POS_W'(PAY_LAST));
  endfunction

  function automatic logic [POS_W-1:0] phase_end(input seq_state_e s);
    case (s)
      ST_HDR:  phase_end = POS_W'(HDR_BYTES - 1);
      ST_FRM:  phase_end = POS_W'(FRM_BYTES - 1);
      default: phase_end = POS_W'(SUP_BYTES - 1);
    endcase
  endfunction

endpackage

// File: rtl/cfg_timer.sv
module cfg_timer #(
  parameter int W = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         load,
  input  logic [W-1:0] val,
  output logic         zero
);
  logic [W-1:0] cnt_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           cnt_q <= '0;
    else if (load)        cnt_q <= val;
    else if (cnt_q != '0) cnt_q <= cnt_q - 1'b1;
  end

  assign zero = (cnt_q == '0);
endmodule

// File: rtl/cfg_pacer.sv
module cfg_pacer #(
  parameter int GAP = 3
) (
  input  logic clk,
  input  logic rst_n,
  input  logic fire,
  output logic slot_ok
);
  localparam int GW = $clog2(GAP + 1);

  logic [GW-1:0] gap_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)           gap_q <= '0;
    else if (fire)        gap_q <= GW'(GAP);
    else if (gap_q != '0) gap_q <= gap_q - 1'b1;
  end

  assign slot_ok = (gap_q == '0);

  // Independent idle counter for the spacing check
  logic [GW-1:0] idle_q;
  logic          seen_q;
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idle_q <= '0;
      seen_q <= 1'b0;
    end else if (fire) begin
      idle_q <= '0;
      seen_q <= 1'b1;
    end else if (idle_q != GW'(GAP)) begin
      idle_q <= idle_q + 1'b1;
    end
  end

  // R10
  fire_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fire |-> slot_ok);
  // R10
  fire_spacing_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fire && seen_q) |-> (idle_q == GW'(GAP)));
endmodule

// File: rtl/cfg_bytegen.sv
module cfg_bytegen
  import cfg_stream_pkg::*;
(
  input  seq_state_e       state,
  input  logic [POS_W-1:0] pos,
  output logic [7:0]       fix_byte,
  output logic             pay_pos
);
  always_comb begin
    case (state)
      ST_HDR:  fix_byte = hdr_byte(pos);
      ST_FRM:  fix_byte = frm_fixed(pos);
      default: fix_byte = 8'hFF;
    endcase
    pay_pos = (state == ST_FRM) && is_pay(pos);
  end
endmodule

// File: rtl/cfg_streamer.sv
module cfg_streamer
  import cfg_stream_pkg::*;
#(
  parameter int PROG_LOW  = 50,
  parameter int INIT_WAIT = 1000000,
  parameter int GAP       = 3
) (
  input  logic       clk,
  input  logic       rst_n,
  input  logic       start,
  output logic       prog_n,
  input  logic       init_n,
  input  logic       done_in,
  input  logic [7:0] pl_data,
  input  logic       pl_valid,
  input  logic       pl_last,
  output logic       pl_ready,
  output logic       wr_strobe,
  output logic [7:0] wr_data,
  output logic       busy,
  output logic       ok,
  output logic       fail,
  output logic [2:0] err_code
);
  localparam int TMAX = (INIT_WAIT > PROG_LOW) ? INIT_WAIT : PROG_LOW;
  localparam int TW   = $clog2(TMAX + 1);

  seq_state_e       state_q;
  logic [POS_W-1:0] pos_q;
  logic             last_seen_q;
  logic             ok_q, fail_q;
  cfg_err_e         err_q;
  logic             strobe_q;
  logic [7:0]       data_q;

  // Named internal events
  logic             tmr_load, tmr_zero;
  logic [TW-1:0]    tmr_val;
  logic             slot_ok, emit;
  logic             writing, init_lost, done_early;
  logic [7:0]       fix_byte;
  logic             pay_pos, pay_slot, phase_done;
  logic [7:0]       emit_byte;

  cfg_timer #(.W(TW)) u_timer (
    .clk(clk), .rst_n(rst_n), .load(tmr_load), .val(tmr_val), .zero(tmr_zero)
  );

  cfg_pacer #(.GAP(GAP)) u_pacer (
    .clk(clk), .rst_n(rst_n), .fire(emit), .slot_ok(slot_ok)
  );

  cfg_bytegen u_bytegen (
    .state(state_q), .pos(pos_q), .fix_byte(fix_byte), .pay_pos(pay_pos)
  );

  always_comb begin
    tmr_load   = ((state_q == ST_IDLE) && start) || ((state_q == ST_PROG) && tmr_zero);
    tmr_val    = (state_q == ST_IDLE) ? TW'(PROG_LOW - 1) : TW'(INIT_WAIT - 1);
    writing    = (state_q == ST_HDR) || (state_q == ST_FRM);
    init_lost  = writing && !init_n;
    done_early = writing && init_n && done_in;
    pay_slot   = pay_pos && !last_seen_q;
    pl_ready   = pay_slot && slot_ok && init_n && !done_in;
    emit       = (writing || (state_q == ST_SUP)) && slot_ok
                 && !init_lost && !done_early
                 && (pay_slot ? pl_valid : 1'b1);
    emit_byte  = pay_slot ? pl_data : fix_byte;
    phase_done = (pos_q == phase_end(state_q));
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q     <= ST_IDLE;
      pos_q       <= '0;
      last_seen_q <= 1'b0;
      ok_q        <= 1'b0;
      fail_q      <= 1'b0;
      err_q       <= E_NONE;
      strobe_q    <= 1'b0;
      data_q      <= 8'h00;
    end else begin
      strobe_q <= emit;
      if (emit) data_q <= emit_byte;
      if (emit && pay_slot && pl_last) last_seen_q <= 1'b1;

      case (state_q)
        ST_IDLE: if (start) begin
          state_q     <= ST_PROG;
          ok_q        <= 1'b0;
          fail_q      <= 1'b0;
          err_q       <= E_NONE;
          last_seen_q <= 1'b0;
        end
        ST_PROG: if (tmr_zero) state_q <= ST_WAIT;
        ST_WAIT: begin
          if (init_n) begin
            state_q <= ST_HDR;
            pos_q   <= '0;
          end else if (tmr_zero) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b1;
            err_q   <= E_TIMEOUT;
          end
        end
        ST_HDR, ST_FRM: begin
          if (init_lost) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b1;
            err_q   <= E_INIT_LOST;
          end else if (done_early) begin
            state_q <= ST_IDLE;
            fail_q  <= 1'b1;
            err_q   <= E_DONE_EARLY;
          end else if (emit) begin
            if (!phase_done) begin
              pos_q <= pos_q + 1'b1;
            end else begin
              pos_q <= '0;
              if (state_q == ST_HDR)  state_q <= ST_FRM;
              else if (last_seen_q)   state_q <= ST_SUP;
            end
          end
        end
        ST_SUP: if (emit) begin
          if (phase_done) begin
            state_q <= ST_CHK;
            pos_q   <= '0;
          end else begin
            pos_q <= pos_q + 1'b1;
          end
        end
        ST_CHK: if (slot_ok) begin
          state_q <= ST_IDLE;
          if (done_in) ok_q <= 1'b1;
          else begin
            fail_q <= 1'b1;
            err_q  <= E_NOT_DONE;
          end
        end
        default: state_q <= ST_IDLE;
      endcase
    end
  end

  assign prog_n    = (state_q != ST_PROG);
  assign busy      = (state_q != ST_IDLE);
  assign wr_strobe = strobe_q;
  assign wr_data   = data_q;
  assign ok        = ok_q;
  assign fail      = fail_q;
  assign err_code  = err_q;

  // R2
  prog_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |-> prog_n);
  // R11
  ready_slot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    pl_ready |-> ((state_q == ST_FRM) && !last_seen_q && init_n));
  // R12
  result_excl_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !(ok && fail));
  // R7
  fail_code_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fail |-> (err_code != 3'd0));
  // R8
  init_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (writing && !init_n) |=> (fail && !busy && err_code == 3'd2));
  // R9
  done_abort_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (writing && init_n && done_in) |=> (fail && !busy && err_code == 3'd3));
  // R10
  strobe_width_chk: assert property (@(posedge clk) disable iff (!rst_n)
    wr_strobe |=> !wr_strobe);
endmodule

// File: tb/tb_cfg_streamer.sv
module tb_cfg_streamer;
  localparam int PROG_LOW  = 4;
  localparam int INIT_WAIT = 40;
  localparam int GAP       = 2;
  localparam int NV        = 9;
  // plen, init release delay, done_at, drop_at, stall, exp_err, exp_bytes
  localparam int VT [NV][7] = '{
    '{21,    5, 38,  0, 0, 0, 40},
    '{30,    5, 68,  0, 1, 0, 68},
    '{42,    3, 67,  0, 0, 0, 68},
    '{ 5,    5, 40,  0, 0, 0, 40},
    '{21,    5,  0,  0, 0, 4, 40},
    '{30,    5, 20,  0, 0, 3, 20},
    '{30,    5,  0, 45, 0, 2, 45},
    '{21, 1000,  0,  0, 0, 1,  0},
    '{21,    5,  5,  0, 1, 3,  5}
  };

  logic clk = 0, rst_n = 0, start = 0;
  logic prog_n, init_n, done_in, pl_ready, pl_valid, pl_last, wr_strobe, busy, ok, fail;
  logic [7:0] pl_data, wr_data;
  logic [2:0] err_code;

  always #4 clk = ~clk;

  cfg_streamer #(.PROG_LOW(PROG_LOW), .INIT_WAIT(INIT_WAIT), .GAP(GAP)) dut (
    .clk(clk), .rst_n(rst_n), .start(start), .prog_n(prog_n), .init_n(init_n),
    .done_in(done_in), .pl_data(pl_data), .pl_valid(pl_valid), .pl_last(pl_last),
    .pl_ready(pl_ready), .wr_strobe(wr_strobe), .wr_data(wr_data), .busy(busy),
    .ok(ok), .fail(fail), .err_code(err_code)
  );

  // Vector settings (written by the initial block only)
  int v_plen, v_rel, v_done, v_drop, v_stall;
  logic clr = 0;

  // Target / source model state
  int nb, pi, rel_cnt, progcnt, since, min_idle, got;
  logic init_r, done_r, dropped, tog;
  logic [7:0] capt [0:127];

  function automatic logic [7:0] dat(input int i);
    return 8'((i * 29 + 11) % 256);
  endfunction

  assign init_n   = init_r;
  assign done_in  = done_r;
  assign pl_valid = (pi < v_plen) && (v_stall == 0 || tog);
  assign pl_data  = dat(pi);
  assign pl_last  = (pi == v_plen - 1);

  initial begin
    nb = 0; pi = 0; rel_cnt = 0; progcnt = 0; since = 0; min_idle = 255; got = 0;
    init_r = 1; done_r = 0; dropped = 0; tog = 0;
    v_plen = 0; v_rel = 0; v_done = 0; v_drop = 0; v_stall = 0;
  end

  always @(posedge clk) begin
    tog <= ~tog;
    if (clr) begin
      nb <= 0; pi <= 0; progcnt <= 0; since <= 0; min_idle <= 255; got <= 0;
      init_r <= 1; done_r <= 0; dropped <= 0; rel_cnt <= 0;
    end else begin
      if (!prog_n) begin
        progcnt <= progcnt + 1;
        rel_cnt <= v_rel;
        init_r  <= 0;
      end else if (rel_cnt != 0) rel_cnt <= rel_cnt - 1;
      else if (!dropped) init_r <= 1;
      if (pl_valid && pl_ready) begin
        pi  <= pi + 1;
        got <= got + 1;
      end
      if (wr_strobe) begin
        if (nb < 128) capt[nb] <= wr_data;
        if (nb != 0 && since < min_idle) min_idle <= since;
        since <= 0;
        nb <= nb + 1;
        if (nb + 1 == v_drop) begin init_r <= 0; dropped <= 1; end
        if (nb + 1 == v_done) done_r <= 1;
      end else begin
        since <= since + 1;
      end
    end
  end

  // Expected stream, built from the requirements
  logic [7:0] exp_b   [0:127];
  logic       exp_pay [0:127];
  int         exp_len;

  task automatic build_exp(input int plen);
    int k = 0;
    int nfr = (plen + 20) / 21;
    logic [7:0] hdr [8] = '{8'hFF, 8'hFF, 8'hFF, 8'h4F, 8'h80, 8'hAF, 8'h9B, 8'h4B};
    logic [7:0] tail [6] = '{8'h4B, 8'hFF, 8'h4B, 8'hFF, 8'hFF, 8'hFF};
    for (int i = 0; i < 8; i++) begin exp_b[k] = hdr[i]; exp_pay[k] = 0; k++; end
    for (int f = 0; f < nfr; f++) begin
      exp_b[k] = 8'h4F; exp_pay[k] = 0; k++;
      for (int j = 0; j < 21; j++) begin
        int src = f * 21 + j;
        exp_b[k]   = (src < plen) ? dat(src) : 8'hFF;
        exp_pay[k] = (src < plen);
        k++;
      end
      for (int t = 0; t < 6; t++) begin exp_b[k] = tail[t]; exp_pay[k] = 0; k++; end
    end
    for (int s = 0; s < 4; s++) begin exp_b[k] = 8'hFF; exp_pay[k] = 0; k++; end
    exp_len = k;
  endtask

  int checks = 0, fails = 0;

  task automatic chk(input bit c, input string tag, input int act, input int exp);
    checks++;
    if (!c) begin
      fails++;
      $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  int cyc = 0;
  always @(posedge clk) begin
    cyc <= cyc + 1;
    if (cyc == 100000) begin
      $display("FAIL watchdog actual=%0d expected=finish", cyc);
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks + 1, fails + 1);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    // R1 reset state
    chk(prog_n && !wr_strobe && !busy && !ok && !fail && !pl_ready && err_code == 0,
        "R1 reset", {prog_n, wr_strobe, busy, ok, fail, pl_ready}, 6'b100000);
    rst_n = 1;
    repeat (2) @(negedge clk);
    chk(prog_n && !busy && !wr_strobe, "R1 idle after reset", {prog_n, busy}, 2'b10);

    for (int v = 0; v < NV; v++) begin
      int mism_h, mism_b, lim, expc, ee, en;
      v_plen = VT[v][0]; v_rel = VT[v][1]; v_done = VT[v][2];
      v_drop = VT[v][3]; v_stall = VT[v][4];
      ee = VT[v][5]; en = VT[v][6];
      build_exp(v_plen);
      clr = 1; @(negedge clk); clr = 0;
      start = 1; @(negedge clk); start = 0;
      // R12 results cleared as the run begins
      chk(busy && !ok && !fail, "R12 cleared on start", {busy, ok, fail}, 3'b100);
      while (busy) @(negedge clk);
      @(negedge clk);

      chk(progcnt == PROG_LOW, "R2 program pulse", progcnt, PROG_LOW);
      chk(nb == en, (ee == 1) ? "R3 byte count" : (ee == 2) ? "R8 byte count" :
          (ee == 3) ? "R9 byte count" : "R7 byte count", nb, en);
      mism_h = 0; mism_b = 0;
      lim = (nb < en) ? nb : en;
      for (int k = 0; k < lim; k++) begin
        if (capt[k] !== exp_b[k]) begin
          if (k < 8) mism_h++; else mism_b++;
        end
      end
      if (lim > 0) chk(mism_h == 0, "R4 header bytes", mism_h, 0);
      if (lim > 8) chk(mism_b == 0, (v_plen % 21 != 0) ? "R6 padded frame bytes" : "R5 frame bytes",
                       mism_b, 0);
      expc = 0;
      for (int k = 0; k < en; k++) if (exp_pay[k]) expc++;
      chk(got == expc, "R11 payload consumed", got, expc);
      if (nb > 1) chk(min_idle >= GAP, "R10 strobe spacing", min_idle, GAP);
      if (ee == 0)
        chk(ok && !fail && err_code == 0, "R7 success", {ok, fail, err_code}, 5'b10000);
      else
        chk(fail && !ok && err_code == 3'(ee),
            (ee == 1) ? "R3 timeout" : (ee == 2) ? "R8 ready lost" :
            (ee == 3) ? "R9 done early" : "R7 done missing", err_code, ee);
      if (ee == 0) begin
        repeat (4) @(negedge clk);
        chk(ok && !fail && !busy, "R12 result held", {ok, fail, busy}, 3'b100);
      end
    end

    // R2 after all runs the program line is released
    chk(prog_n, "R2 released when idle", prog_n, 1);
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", checks, fails);
    $finish;
  end
endmodule